// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a single-word load or store and the value the base register should take after the access. A request presents a base register value, an offset (either a zero-extended immediate or a register value shifted left by a 0 to 31 bit amount), a direction (add or subtract), an indexing mode and a write-back request. Each request is qualified by a one-cycle valid strobe.

The indexing mode is one of three:
- **Base-only:** the access uses the base as is.
- **Pre-indexed:** the access uses base plus or minus the offset, and that sum is returned to the base only when write-back is requested.
- **Post-indexed:** the access uses the unmodified base, and the base is always moved by the offset.

The address, the new base and a one-cycle base write-enable are registered. They appear one clock after the valid strobe. All arithmetic wraps modulo 2^AW.

Top module: `ldst_agu`

## Requirements
- R1: While rst_n is low and after its release, before any valid request, addr_q and nbase_q are zero and base_we_q is low.
- R2: Mode code 2'b00 (base-only) and the unused code 2'b11 give addr_q = base and nbase_q = base, with base_we_q low, whatever the offset and write-back inputs.
- R3: Mode code 2'b01 (pre-indexed) gives addr_q = base + offset when up=1 and base - offset when up=0; base 0x200 with immediate 12 gives 0x20C up and 0x1F4 down.
- R4: In pre-indexed mode, nbase_q equals addr_q and base_we_q equals wb_req; with wb_req=0, nbase_q is the unchanged base.
- R5: Mode code 2'b10 (post-indexed) gives addr_q = base and nbase_q = base plus or minus the offset, with base_we_q high regardless of wb_req.
- R6: With off_sel=1 the offset is reg_off shifted left by shamt (0 to 31), with bits shifted past bit AW-1 discarded; reg_off 3 with shamt 2 gives 12.
- R7: With off_sel=0 the offset is imm_off zero-extended to AW bits.
- R8: Sums and differences wrap modulo 2^AW, for example 0xFFFFFFF8 + 12 = 0x4 and 0x4 - 12 = 0xFFFFFFF8.
- R9: The outputs change exactly one clock after a cycle with in_vld high and reflect that cycle's inputs.
- R10: base_we_q is high for at most one cycle per request. It is low after any cycle with in_vld low, and addr_q and nbase_q then hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Request strobe, one cycle per request |
| base_val | input | AW | Base register value |
| imm_off | input | IMMW | Immediate offset magnitude |
| reg_off | input | AW | Register offset before shifting |
| off_sel | input | 1 | 0 selects immediate, 1 selects shifted register |
| shamt | input | SHW | Left-shift amount for the register offset |
| up | input | 1 | 1 adds the offset, 0 subtracts it |
| idx_mode | input | 2 | 00 base-only, 01 pre-indexed, 10 post-indexed, 11 as base-only |
| wb_req | input | 1 | Write-back request (pre-indexed only) |
| addr_q | output | AW | Registered effective address |
| nbase_q | output | AW | Registered updated base value |
| base_we_q | output | 1 | Registered base write-enable |

## Verification
The hardest situations to reach are the high-order bits of a shifted register offset falling off the top of the word, and an add or subtract crossing the 2^32 boundary. A random sweep rarely produces either. The bench therefore pairs a full sweep of every mode, direction, write-back setting, offset source and all 32 shift amounts with base values chosen near zero and near the top of the address space. It also uses a register offset whose top bit is set. An idle cycle follows every request, so that both the single-cycle write-enable and the holding of the outputs are observed.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;
   typedef enum logic [1:0] {
      IDX_BASE = 2'b00,
      IDX_PRE  = 2'b01,
      IDX_POST = 2'b10,
      IDX_RSVD = 2'b11
   } idx_mode_e;
endpackage

// File: rtl/ldst_off_unit.sv
module ldst_off_unit #(
   parameter int AW   = 32,
   parameter int IMMW = 12,
   parameter int SHW  = 5
) (
   input  logic [IMMW-1:0] imm_off,
   input  logic [AW-1:0]   reg_off,
   input  logic            off_sel,
   input  logic [SHW-1:0]  shamt,
   output logic [AW-1:0]   offset
);
   localparam int PADW = AW - IMMW;

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] reg_shl;

   initial begin
      if (IMMW > AW) $error("ldst_off_unit: IMMW exceeds AW");
      if ((1 << SHW) > AW) $error("ldst_off_unit: shift range exceeds AW");
   end

   generate
      if (PADW > 0) begin : g_imm_pad
         assign imm_ext = {{PADW{1'b0}}, imm_off};
      end else begin : g_imm_full
         assign imm_ext = imm_off[AW-1:0];
      end
   endgenerate

   assign reg_shl = reg_off << shamt;
   assign offset  = off_sel ? reg_shl : imm_ext;
endmodule

// File: rtl/ldst_sum_unit.sv
module ldst_sum_unit #(
   parameter int AW          = 32,
   parameter bit NEG_BY_CMPL = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] offset,
   input  logic          up,
   output logic [AW-1:0] sum
);
   generate
      if (NEG_BY_CMPL) begin : g_cmpl
         logic [AW-1:0] opnd;
         assign opnd = up ? offset : ~offset;
         assign sum  = base + opnd + {{(AW-1){1'b0}}, ~up};
      end else begin : g_dual
         assign sum = up ? (base + offset) : (base - offset);
      end
   endgenerate
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
   import ldst_agu_pkg::*;
#(
   parameter int AW          = 32,
   parameter int IMMW        = 12,
   parameter int SHW         = 5,
   parameter bit NEG_BY_CMPL = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [AW-1:0]   base_val,
   input  logic [IMMW-1:0] imm_off,
   input  logic [AW-1:0]   reg_off,
   input  logic            off_sel,
   input  logic [SHW-1:0]  shamt,
   input  logic            up,
   input  logic [1:0]      idx_mode,
   input  logic            wb_req,
   output logic [AW-1:0]   addr_q,
   output logic [AW-1:0]   nbase_q,
   output logic            base_we_q
);
   initial begin
      if (AW < 8) $error("ldst_agu: AW too small");
      if (IMMW < 1) $error("ldst_agu: IMMW must be positive");
      if (SHW < 1) $error("ldst_agu: SHW must be positive");
   end

   logic [AW-1:0] offset;
   logic [AW-1:0] moved;
   logic [AW-1:0] addr_d;
   logic [AW-1:0] nbase_d;
   logic          we_d;
   idx_mode_e     mode;

   assign mode = idx_mode_e'(idx_mode);

   ldst_off_unit #(.AW(AW), .IMMW(IMMW), .SHW(SHW)) u_off (
      .imm_off (imm_off),
      .reg_off (reg_off),
      .off_sel (off_sel),
      .shamt   (shamt),
      .offset  (offset)
   );

   ldst_sum_unit #(.AW(AW), .NEG_BY_CMPL(NEG_BY_CMPL)) u_sum (
      .base   (base_val),
      .offset (offset),
      .up     (up),
      .sum    (moved)
   );

   always_comb begin
      addr_d  = base_val;
      nbase_d = base_val;
      we_d    = 1'b0;
      unique case (mode)
         IDX_PRE: begin
            addr_d  = moved;
            nbase_d = wb_req ? moved : base_val;
            we_d    = wb_req;
         end
         IDX_POST: begin
            nbase_d = moved;
            we_d    = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q    <= '0;
         nbase_q   <= '0;
         base_we_q <= 1'b0;
      end else begin
         base_we_q <= in_vld & we_d;
         if (in_vld) begin
            addr_q  <= addr_d;
            nbase_q <= nbase_d;
         end
      end
   end

   AST_WE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
      base_we_q |-> $past(in_vld)) else $error("we without valid"); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_vld) |-> ($stable(addr_q) && $stable(nbase_q))) else $error("outputs moved while idle"); // R10
   AST_POST_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && idx_mode == 2'b10) |-> base_we_q) else $error("post without we"); // R5
   AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && idx_mode == 2'b10) |-> addr_q == $past(base_val)) else $error("post address"); // R5
   AST_PRE_WB: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && idx_mode == 2'b01 && wb_req) |-> (nbase_q == addr_q && base_we_q)) else $error("pre writeback"); // R4
   AST_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_vld && (idx_mode == 2'b00 || idx_mode == 2'b11)) |-> (!base_we_q && addr_q == $past(base_val))) else $error("base-only"); // R2
endmodule

// File: tb/tb_ldst_agu.sv
module tb_ldst_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [31:0] base_val = '0;
   logic [11:0] imm_off = '0;
   logic [31:0] reg_off = '0;
   logic        off_sel = 1'b0;
   logic [4:0]  shamt = '0;
   logic        up = 1'b0;
   logic [1:0]  idx_mode = '0;
   logic        wb_req = 1'b0;
   logic [31:0] addr_q, nbase_q;
   logic        base_we_q;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ldst_agu dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .base_val(base_val),
      .imm_off(imm_off), .reg_off(reg_off), .off_sel(off_sel), .shamt(shamt),
      .up(up), .idx_mode(idx_mode), .wb_req(wb_req),
      .addr_q(addr_q), .nbase_q(nbase_q), .base_we_q(base_we_q)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // drive one request, check it one clock later, then check an idle cycle
   task automatic run(logic [31:0] b, logic [11:0] im, logic [31:0] ro, logic sel,
                      logic [4:0] sh, logic u, logic [1:0] m, logic wb);
      logic [31:0] off, mv, ea, nb;
      logic        we;
      off = sel ? (ro << sh) : {20'd0, im};          // R6 R7
      mv  = u ? (b + off) : (b - off);               // R8
      ea = b; nb = b; we = 1'b0;                     // R2
      if (m == 2'b01) begin ea = mv; nb = wb ? mv : b; we = wb; end   // R3 R4
      if (m == 2'b10) begin nb = mv; we = 1'b1; end                    // R5
      @(negedge clk);
      base_val = b; imm_off = im; reg_off = ro; off_sel = sel; shamt = sh;
      up = u; idx_mode = m; wb_req = wb; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      base_val = ~b; imm_off = ~im; reg_off = ~ro; idx_mode = 2'b10; wb_req = ~wb;
      chk("R9 addr", addr_q, ea);
      chk("R9 nbase", nbase_q, nb);
      chk("R3/R5 we", {31'd0, base_we_q}, {31'd0, we});
      @(negedge clk);
      chk("R10 we idle", {31'd0, base_we_q}, 32'd0);
      chk("R10 addr hold", addr_q, ea);
      chk("R10 nbase hold", nbase_q, nb);
   endtask

   initial begin
      #20000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] bases [4];
      bases[0] = 32'h0000_0200; bases[1] = 32'h0000_0004;
      bases[2] = 32'hFFFF_FFF8; bases[3] = 32'h8000_0000;
      repeat (3) @(negedge clk);
      chk("R1 addr in reset", addr_q, 32'd0);
      chk("R1 we in reset", {31'd0, base_we_q}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 addr", addr_q, 32'd0);
      chk("R1 nbase", nbase_q, 32'd0);
      chk("R1 we", {31'd0, base_we_q}, 32'd0);

      // directed examples
      run(32'h200, 12'd12, 32'd0, 1'b0, 5'd0, 1'b1, 2'b01, 1'b0);   // R3 0x20C
      chk("R3 up example", addr_q, 32'h20C);
      run(32'h200, 12'd12, 32'd0, 1'b0, 5'd0, 1'b0, 2'b01, 1'b1);   // R3 0x1F4, R4
      chk("R3 down example", addr_q, 32'h1F4);
      chk("R4 wb example", nbase_q, 32'h1F4);
      run(32'h200, 12'd0, 32'd3, 1'b1, 5'd2, 1'b1, 2'b01, 1'b0);    // R6
      chk("R6 scaled example", addr_q, 32'h20C);
      run(32'h200, 12'd12, 32'd0, 1'b0, 5'd0, 1'b1, 2'b10, 1'b0);   // R5
      chk("R5 post addr", addr_q, 32'h200);
      chk("R5 post base", nbase_q, 32'h20C);
      run(32'hFFFF_FFF8, 12'd12, 32'd0, 1'b0, 5'd0, 1'b1, 2'b01, 1'b0);  // R8
      chk("R8 wrap up", addr_q, 32'h4);
      run(32'h4, 12'd12, 32'd0, 1'b0, 5'd0, 1'b0, 2'b01, 1'b0);          // R8
      chk("R8 wrap down", addr_q, 32'hFFFF_FFF8);
      run(32'h0, 12'd0, 32'h8000_0001, 1'b1, 5'd1, 1'b1, 2'b01, 1'b0);   // R6 drop
      chk("R6 top bit dropped", addr_q, 32'h2);
      run(32'h0, 12'hFFF, 32'd0, 1'b0, 5'd0, 1'b1, 2'b01, 1'b0);         // R7
      chk("R7 imm zero-ext", addr_q, 32'h0000_0FFF);
      run(32'h1234, 12'hFFF, 32'hFF, 1'b1, 5'd7, 1'b0, 2'b11, 1'b1);     // R2 reserved
      chk("R2 reserved code", addr_q, 32'h1234);

      // sweep
      for (int bi = 0; bi < 4; bi++)
         for (int m = 0; m < 4; m++)
            for (int u = 0; u < 2; u++)
               for (int wb = 0; wb < 2; wb++) begin
                  run(bases[bi], 12'hA5C, 32'hC000_0013, 1'b0, 5'd0,
                      1'(u), 2'(m), 1'(wb));
                  for (int sh = 0; sh < 32; sh++)
                     run(bases[bi], 12'h3, 32'hC000_0013, 1'b1, 5'(sh),
                         1'(u), 2'(m), 1'(wb));
               end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule